// File: doc/BRIEF.md
# PLL configuration lock tracker

This block holds the settings of a frequency-multiplying PLL and reports when the PLL may be considered locked. One write strobe loads three fields together: an 11-bit multiplier, an input divider and a lock count. The analog PLL is outside the block. Here it is represented by a run enable, the effective multiplication factor and a lock flag that is driven by a countdown.

The block runs on one fast clock. The slow clock reaches it as a one-cycle strobe, `slow_tick`. A write that changes the multiplier or the divider, and that leaves the PLL running, clears the lock flag and restarts the countdown from the new lock count. Each slow tick after that write lowers the count. The flag rises on the tick that follows the count reaching zero. A write that keeps both the multiplier and the divider the same leaves the flag and the countdown alone. If either field is zero, the PLL counts as off: the flag stays low and no countdown runs. The lock flag can drive an interrupt line through a mask input.

Top module: `pll_lock_tracker`

## Requirements
- R1: After reset, `locked`, `pll_en`, `mult_factor` and `irq` are 0 and `pll_off` is 1.
- R2: When the PLL is on, `mult_factor` equals the stored multiplier plus one. A multiplier of 2047 gives 2048.
- R3: `pll_off` is 1, `pll_en` is 0 and `mult_factor` is 0 whenever the stored multiplier or the stored divider is 0. Any divider other than 0 counts as on.
- R4: A write with the PLL left on that changes the multiplier or the divider makes `locked` 0 in the next cycle. `locked` then rises in the cycle after the (N+1)-th slow tick that follows the write cycle, where N is the lock count written. This holds for N up to 63.
- R5: A lock count of 0 sets `locked` on the first slow tick after the write. A tick in the write cycle itself is not counted.
- R6: A write whose multiplier and divider both equal the stored values does not change `locked`, and it does not restart a countdown in progress, whatever lock count it carries.
- R7: A change of the multiplier or the divider during a countdown, or after lock, restarts the countdown with the newly written count.
- R8: While the PLL is off, `locked` stays 0 and slow ticks have no effect. A later write that turns the PLL on starts a fresh countdown.
- R9: In level mode, `irq` equals `locked` AND `irq_en`.
- R10: `locked` rises only in the cycle after a slow tick. Fast-clock cycles without a tick never complete a countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock edge |
| cfg_we | input | 1 | Write strobe for all three fields |
| cfg_mul | input | MUL_W (11) | Multiplier field; 0 turns the PLL off |
| cfg_div | input | DIV_W (8) | Divider field; 0 turns the PLL off |
| cfg_cnt | input | CNT_W (6) | Lock count in slow ticks |
| irq_en | input | 1 | Lock interrupt mask, 1 = enabled |
| locked | output | 1 | Lock flag |
| pll_off | output | 1 | PLL turned off by the stored fields |
| pll_en | output | 1 | Run enable to the PLL |
| mult_factor | output | MUL_W+1 (12) | Effective multiplication factor, 0 when off |
| irq | output | 1 | Lock interrupt |

## Verification
The bench builds the block with an 11-bit multiplier, an 8-bit divider, a 6-bit lock count and the level interrupt. The full multiplier width brings the 2047 boundary, and its factor of 2048, within reach. The narrow count field makes the longest lock delay, 64 slow ticks, cheap to run through to the end. Directed sequences cover:
- restarts in the middle of a countdown;
- writes that change nothing;
- ticks that land in the write cycle;
- off states made by a zero multiplier and by a zero divider.

A long random phase mixes writes, ticks and mask changes against the behavioural model.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,
      LK_COUNT = 2'd1,
      LK_DONE  = 2'd2
   } lock_state_e;

   function automatic logic fields_off(input logic mul_zero, input logic div_zero);
      return mul_zero | div_zero;
   endfunction
endpackage

// File: rtl/pll_cfg_store.sv
module pll_cfg_store #(
   parameter int MUL_W = 11,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [MUL_W-1:0] mul_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [MUL_W-1:0] mul_q,
   output logic             off_q,
   output logic             wr_change,
   output logic             wr_off
);
   import pll_lock_pkg::*;

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mul_q <= '0;
         div_q <= '0;
         off_q <= 1'b1;
      end else if (we_i) begin
         mul_q <= mul_i;
         div_q <= div_i;
         off_q <= fields_off(mul_i == '0, div_i == '0);
      end
   end

   always_comb begin
      wr_change = we_i && ((mul_i != mul_q) || (div_i != div_q));
      wr_off    = we_i && fields_off(mul_i == '0, div_i == '0);
   end
endmodule

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             kill_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             locked_o
);
   import pll_lock_pkg::*;

   lock_state_e      state_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LK_IDLE;
         left_q  <= '0;
      end else if (kill_i) begin
         state_q <= LK_IDLE;
      end else if (load_i) begin
         state_q <= LK_COUNT;
         left_q  <= cnt_i;
      end else if (state_q == LK_COUNT && tick_i) begin
         if (left_q == '0) state_q <= LK_DONE;
         else              left_q  <= left_q - 1'b1;
      end
   end

   assign locked_o = (state_q == LK_DONE);

   AST_LOCK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(tick_i)); // R10
endmodule

// File: rtl/pll_irq_gate.sv
module pll_irq_gate #(
   parameter bit PULSE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic locked_i,
   input  logic en_i,
   output logic irq_o
);
   generate
      if (PULSE) begin : g_pulse
         logic locked_d;
         always_ff @(posedge clk) begin
            if (!rst_n) locked_d <= 1'b0;
            else        locked_d <= locked_i;
         end
         assign irq_o = locked_i & ~locked_d & en_i;
      end else begin : g_level
         assign irq_o = locked_i & en_i;
      end
   endgenerate

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |-> !irq_o); // R9
endmodule

// File: rtl/pll_lock_tracker.sv
module pll_lock_tracker #(
   parameter int MUL_W     = 11,
   parameter int DIV_W     = 8,
   parameter int CNT_W     = 6,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             cfg_we,
   input  logic [MUL_W-1:0] cfg_mul,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_cnt,
   input  logic             irq_en,
   output logic             locked,
   output logic             pll_off,
   output logic             pll_en,
   output logic [MUL_W:0]   mult_factor,
   output logic             irq
);
   localparam int FAC_W = MUL_W + 1;

   generate
      if (MUL_W < 1 || MUL_W > 16) begin : g_bad_mul
         $error("pll_lock_tracker: MUL_W out of range");
      end
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("pll_lock_tracker: DIV_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_cnt
         $error("pll_lock_tracker: CNT_W out of range");
      end
   endgenerate

   logic [MUL_W-1:0] mul_q;
   logic             off_q;
   logic             wr_change;
   logic             wr_off;
   logic             t_kill;
   logic             t_load;

   pll_cfg_store #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (cfg_we),
      .mul_i     (cfg_mul),
      .div_i     (cfg_div),
      .mul_q     (mul_q),
      .off_q     (off_q),
      .wr_change (wr_change),
      .wr_off    (wr_off)
   );

   assign t_kill = wr_off;
   assign t_load = wr_change & ~wr_off;

   pll_lock_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (slow_tick),
      .kill_i   (t_kill),
      .load_i   (t_load),
      .cnt_i    (cfg_cnt),
      .locked_o (locked)
   );

   pll_irq_gate #(.PULSE(IRQ_PULSE)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .locked_i (locked),
      .en_i     (irq_en),
      .irq_o    (irq)
   );

   assign pll_off     = off_q;
   assign pll_en      = ~off_q;
   assign mult_factor = off_q ? '0 : ({1'b0, mul_q} + FAC_W'(1));

   AST_OFF_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      pll_off |-> !locked); // R8
   AST_CHANGE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_change |=> !locked); // R4
   AST_SAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !wr_change && !slow_tick) |=> $stable(locked)); // R6
   AST_FACTOR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      pll_en |-> (mult_factor != '0)); // R2
endmodule

// File: tb/pll_lock_tracker_test.sv
module pll_lock_tracker_test;
   localparam int MW = 11;
   localparam int DW = 8;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_tick = 1'b0;
   logic          cfg_we = 1'b0;
   logic [MW-1:0] cfg_mul = '0;
   logic [DW-1:0] cfg_div = '0;
   logic [CW-1:0] cfg_cnt = '0;
   logic          irq_en = 1'b0;
   logic          locked, pll_off, pll_en, irq;
   logic [MW:0]   mult_factor;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   pll_lock_tracker #(.MUL_W(MW), .DIV_W(DW), .CNT_W(CW), .IRQ_PULSE(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cfg_we(cfg_we),
      .cfg_mul(cfg_mul), .cfg_div(cfg_div), .cfg_cnt(cfg_cnt), .irq_en(irq_en),
      .locked(locked), .pll_off(pll_off), .pll_en(pll_en),
      .mult_factor(mult_factor), .irq(irq)
   );

   // behavioural reference
   int m_mul, m_div, m_left;
   bit m_lock, m_run;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_mul = 0; m_div = 0; m_left = 0; m_lock = 0; m_run = 0;
      end else begin
         bit chg, off_now, acted;
         acted = 0;
         if (cfg_we) begin
            chg = (int'(cfg_mul) != m_mul) || (int'(cfg_div) != m_div);
            m_mul = int'(cfg_mul);
            m_div = int'(cfg_div);
            off_now = (m_mul == 0) || (m_div == 0);
            if (off_now) begin
               m_lock = 0; m_run = 0; acted = 1;
            end else if (chg) begin
               m_lock = 0; m_run = 1; m_left = int'(cfg_cnt) + 1; acted = 1;
            end
         end
         if (!acted && m_run && slow_tick) begin
            m_left = m_left - 1;
            if (m_left == 0) begin m_lock = 1; m_run = 0; end
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always begin
      @(posedge clk);
      #6;
      if (rst_n && !done) begin
         bit moff;
         moff = (m_mul == 0) || (m_div == 0);
         chk("R4 model locked", int'(locked), int'(m_lock));
         chk("R3 model pll_off", int'(pll_off), int'(moff));
         chk("R3 model pll_en", int'(pll_en), int'(!moff));
         chk("R2 model factor", int'(mult_factor), moff ? 0 : m_mul + 1);
         chk("R9 model irq", int'(irq), int'(m_lock && irq_en));
      end
   end

   task automatic cyc(input bit we, input int mul, input int dv, input int cnt, input bit tk);
      @(negedge clk);
      cfg_we = we; cfg_mul = MW'(mul); cfg_div = DW'(dv); cfg_cnt = CW'(cnt); slow_tick = tk;
      @(posedge clk);
      #1;
      @(negedge clk);
      cfg_we = 1'b0; slow_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
   endtask

   task automatic tick_chk(input int n, input string req, input int exp_lock);
      for (int i = 0; i < n; i++) begin
         cyc(0, 0, 0, 0, 1);
         chk(req, int'(locked), exp_lock);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      // R1 reset state
      chk("R1 locked", int'(locked), 0);
      chk("R1 pll_off", int'(pll_off), 1);
      chk("R1 pll_en", int'(pll_en), 0);
      chk("R1 factor", int'(mult_factor), 0);
      chk("R1 irq", int'(irq), 0);
      irq_en = 1'b1;

      // R2 / R4 basic lock
      cyc(1, 5, 1, 3, 0);
      chk("R2 factor", int'(mult_factor), 6);
      chk("R3 on", int'(pll_off), 0);
      chk("R4 dropped", int'(locked), 0);
      tick_chk(3, "R4 before count", 0);
      tick_chk(1, "R4 after count", 1);
      chk("R9 irq enabled", int'(irq), 1);
      @(negedge clk); irq_en = 1'b0;
      idle(1);
      chk("R9 irq masked", int'(irq), 0);
      @(negedge clk); irq_en = 1'b1;

      // R6 unchanged write while locked
      cyc(1, 5, 1, 50, 0);
      chk("R6 same write keeps lock", int'(locked), 1);
      idle(2);
      chk("R6 still locked", int'(locked), 1);

      // R5 zero count, tick in write cycle ignored
      cyc(1, 7, 1, 0, 1);
      chk("R5 write-cycle tick ignored", int'(locked), 0);
      tick_chk(1, "R5 zero count", 1);

      // R7 restart mid-count
      cyc(1, 3, 1, 5, 0);
      ticks(2);
      cyc(1, 4, 1, 1, 0);
      chk("R7 restart low", int'(locked), 0);
      tick_chk(1, "R7 new count pending", 0);
      tick_chk(1, "R7 new count done", 1);
      cyc(1, 4, 2, 0, 0);
      chk("R7 divider change drops", int'(locked), 0);
      chk("R2 factor after divider change", int'(mult_factor), 5);
      tick_chk(1, "R7 divider relock", 1);

      // R6 unchanged write mid-countdown
      cyc(1, 9, 1, 2, 0);
      ticks(2);
      cyc(1, 9, 1, 40, 0);
      chk("R6 no restart low", int'(locked), 0);
      tick_chk(1, "R6 original count completes", 1);

      // R10 no lock without ticks
      cyc(1, 6, 1, 1, 0);
      ticks(1);
      idle(20);
      chk("R10 no tick no lock", int'(locked), 0);
      tick_chk(1, "R10 tick completes", 1);

      // R3 / R8 off states
      cyc(1, 0, 1, 0, 0);
      chk("R3 mul zero off", int'(pll_off), 1);
      chk("R3 mul zero factor", int'(mult_factor), 0);
      chk("R8 off unlocked", int'(locked), 0);
      tick_chk(10, "R8 ticks ignored while off", 0);
      cyc(1, 3, 0, 0, 0);
      chk("R3 div zero off", int'(pll_off), 1);
      chk("R3 div zero enable", int'(pll_en), 0);
      tick_chk(3, "R8 div zero ticks ignored", 0);
      cyc(1, 3, 1, 1, 0);
      chk("R8 turned on", int'(pll_en), 1);
      tick_chk(1, "R8 fresh count pending", 0);
      tick_chk(1, "R8 fresh count done", 1);

      // R2 / R4 boundaries
      cyc(1, 2047, 1, 63, 0);
      chk("R2 max factor", int'(mult_factor), 2048);
      ticks(62);
      tick_chk(1, "R4 max count pending", 0);
      tick_chk(1, "R4 max count done", 1);

      // random mix against the model
      for (int i = 0; i < 3000; i++) begin
         bit we, tk;
         int mul, dv;
         we = ($urandom_range(0, 19) == 0);
         tk = ($urandom_range(0, 2) == 0);
         mul = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 3);
         dv = $urandom_range(0, 4) == 0 ? 0 : $urandom_range(1, 2);
         if ($urandom_range(0, 30) == 0) irq_en = ~irq_en;
         cyc(we, mul, dv, $urandom_range(0, 7), tk);
      end

      idle(2);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule